// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block holds the modem-status byte of a serial port. It watches four active-low handshake pins: clear-to-send, data-set-ready, ring indicator and carrier detect. It shows each one as an active-high level bit. It also keeps a sticky change flag for each line, and those flags drop when software reads the byte. The ring-indicator flag is special: it records only the moment the ring pin returns high, which marks the end of a ring. Any other line flags a change in either direction.

When the loopback control is high, the pins are cut off. The four low modem-control bits then drive the levels and the change flags instead. These bits are data-terminal-ready, request-to-send and the two general outputs. The same flags feed an interrupt request, and that request is masked by its own enable. A read strobe marks the cycle in which the host consumes the byte. The byte itself is always visible on the read-data port.

Top module: `msr_block`

## Requirements
- R1: After reset, rd_data is 0x00 and irq is low.
- R2: rd_data bits 4, 5, 6 and 7 show the inverted level of cts_n, dsr_n, ri_n and dcd_n. A pin change appears on the third rising clock edge after it is applied, because it passes two synchronizer flops and the status register.
- R3: rd_data bit 0 sets on any change of cts_n. Bit 1 sets on any change of dsr_n. Bit 3 sets on any change of dcd_n. Each flag sets in the same cycle that the matching level bit changes.
- R4: rd_data bit 2 sets when ri_n goes from low to high, which means the RI level bit falls. It does not set when ri_n goes from high to low.
- R5: A change flag stays set until a cycle with rd_stb high. The value read in that cycle is the pre-clear byte, and the flags are zero from the next cycle on.
- R6: If a change reaches the status register in the same cycle as rd_stb, its flag is set rather than cleared, so the next read reports it.
- R7: While loop_en is high, the level bits follow mcr_lo one cycle later. Bit 4 follows mcr_lo[1] (request-to-send), bit 5 follows mcr_lo[0] (terminal-ready), bit 6 follows mcr_lo[2] (output 1) and bit 7 follows mcr_lo[3] (output 2). The change flags, including the trailing-edge rule for bit 2, apply to these sources.
- R8: While loop_en is high, changes on the four pins have no effect on rd_data or irq.
- R9: When loop_en toggles, any line whose selected source differs from the old level is reported as a change.
- R10: irq is high exactly when irq_en is high and at least one of rd_data bits 0 to 3 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring-indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| loop_en | input | 1 | Internal loopback select |
| mcr_lo | input | 4 | Modem-control bits: [0] terminal-ready, [1] request-to-send, [2] output 1, [3] output 2 |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | Read strobe; clears change flags at the end of its cycle |
| rd_data | output | 8 | {levels DCD,RI,DSR,CTS, flags DCD,RI-trailing,DSR,CTS} |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a change that arrives in the same cycle as a read. It only occurs when a pin edge, delayed through the synchronizer, lands on the clock edge that also sees the strobe.

The stimulus changes a pin on a falling edge. It then counts two rising edges and raises the strobe for the third. The first read must show the old byte, and the following read must show the kept flag.

The loopback sequence steps the control bits through all four lines in turn. This hits both directions of the ring source. It also toggles the pins while they are cut off, so their isolation can be checked.

// File: rtl/msr_pkg.sv
// Package: shared constants for the modem status register.
// Line indices are fixed because the byte layout depends on them.
package msr_pkg;
    localparam int MSR_LINES = 4;
    localparam int LN_CTS    = 0;
    localparam int LN_DSR    = 1;
    localparam int LN_RI     = 2;
    localparam int LN_DCD    = 3;
    // Modem-control bit positions used as loopback sources
    localparam int MC_DTR    = 0;
    localparam int MC_RTS    = 1;
    localparam int MC_OUT1   = 2;
    localparam int MC_OUT2   = 3;
endpackage

// File: rtl/mstat_sync.sv
// Module: mstat_sync
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent, so no bus coherency is needed.
// Reset loads RST_VAL, the idle level of the pins.
module mstat_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pins into the first flop
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Shift toward the settled stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/mstat_src_sel.sv
// Module: mstat_src_sel
// Picks the active-high level of each line.
// Outside loopback, each level is the inverse of a synchronized pin.
// In loopback, each level comes from a modem-control bit.
// Assumes the control bits are already synchronous to clk.
module mstat_src_sel
    import msr_pkg::*;
(
    input  logic                 loop_en,
    input  logic [MSR_LINES-1:0] pin_sync_n,
    input  logic [MSR_LINES-1:0] mcr_lo,
    output logic [MSR_LINES-1:0] level
);
    logic [MSR_LINES-1:0] loop_level;

    // Route each control bit to the line it stands in for
    always_comb begin
        loop_level         = '0;
        loop_level[LN_CTS] = mcr_lo[MC_RTS];
        loop_level[LN_DSR] = mcr_lo[MC_DTR];
        loop_level[LN_RI]  = mcr_lo[MC_OUT1];
        loop_level[LN_DCD] = mcr_lo[MC_OUT2];
    end

    // Choose between loopback and pin sources
    always_comb begin
        level = loop_en ? loop_level : ~pin_sync_n;
    end
endmodule

// File: rtl/mstat_delta.sv
// Module: mstat_delta
// Holds the registered line levels and sticky change flags.
// A line in TRAIL_MASK flags only a level fall; the others flag any change.
// A read clears the flags, but a change in the same cycle wins.
module mstat_delta #(
    parameter int               LINES      = 4,
    parameter logic [LINES-1:0] TRAIL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] level_in,
    input  logic             rd_stb,
    output logic [LINES-1:0] level_q,
    output logic [LINES-1:0] delta_q
);
    logic [LINES-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < LINES; i++) begin : g_line
            if (TRAIL_MASK[i]) begin : g_trail
                // Flag only a level fall (the pin returning high)
                always_comb hit[i] = level_q[i] & ~level_in[i];
            end else begin : g_any
                // Flag a change in either direction
                always_comb hit[i] = level_q[i] ^ level_in[i];
            end
        end
    endgenerate

    // Register the levels and update the flags, letting set beat clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            delta_q <= '0;
        end else begin
            level_q <= level_in;
            delta_q <= (rd_stb ? '0 : delta_q) | hit;
        end
    end
endmodule

// File: rtl/msr_block.sv
// Module: msr_block (top)
// Modem status register with change flags, loopback and interrupt request.
// Assumes the pins are asynchronous, idle high, and that mcr_lo, loop_en,
// irq_en and rd_stb are synchronous to clk.
module msr_block
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       dcd_n,
    input  logic       loop_en,
    input  logic [3:0] mcr_lo,
    input  logic       irq_en,
    input  logic       rd_stb,
    output logic [7:0] rd_data,
    output logic       irq
);
    localparam logic [MSR_LINES-1:0] TRAIL = MSR_LINES'(1) << LN_RI;

    logic [MSR_LINES-1:0] pins_n;
    logic [MSR_LINES-1:0] pins_sync_n;
    logic [MSR_LINES-1:0] level_sel;
    logic [MSR_LINES-1:0] level_q;
    logic [MSR_LINES-1:0] delta_q;

    // Gather the pins in line-index order
    always_comb begin
        pins_n         = '1;
        pins_n[LN_CTS] = cts_n;
        pins_n[LN_DSR] = dsr_n;
        pins_n[LN_RI]  = ri_n;
        pins_n[LN_DCD] = dcd_n;
    end

    mstat_sync #(
        .WIDTH   (MSR_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_n),
        .sync_out (pins_sync_n)
    );

    mstat_src_sel u_sel (
        .loop_en    (loop_en),
        .pin_sync_n (pins_sync_n),
        .mcr_lo     (mcr_lo),
        .level      (level_sel)
    );

    mstat_delta #(
        .LINES      (MSR_LINES),
        .TRAIL_MASK (TRAIL)
    ) u_delta (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (level_sel),
        .rd_stb   (rd_stb),
        .level_q  (level_q),
        .delta_q  (delta_q)
    );

    // Present the byte and the masked request
    always_comb begin
        rd_data = {level_q, delta_q};
        irq     = irq_en & (|delta_q);
    end
endmodule

// File: rtl/msr_block_chk.sv
// Module: msr_block_chk
// Assertion checker for msr_block, attached with bind below.
// It observes only the top-level ports.
module msr_block_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loop_en,
    input logic [3:0] mcr_lo,
    input logic       irq_en,
    input logic       rd_stb,
    input logic [7:0] rd_data,
    input logic       irq
);
    // R3: a CTS level change is always flagged
    assert_cts_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data[4]) |-> rd_data[0]);

    // R4: an RI level fall sets the trailing flag
    assert_ri_trail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[6]) |-> rd_data[2]);

    // R4: an RI level rise does not set the trailing flag
    assert_ri_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_data[6]) && !$past(rd_data[2])) |-> !rd_data[2]);

    // R5: the flags clear after a read when no level moved
    assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (!$stable(rd_data[7:4]) || rd_data[3:0] == 4'd0));

    // R5: the flags hold without a read
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && !rd_stb) |=> rd_data[0]);

    // R7: loopback levels follow the control bits one cycle later
    assert_loop_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(loop_en)) |->
        rd_data[7:4] == {$past(mcr_lo[3]), $past(mcr_lo[2]), $past(mcr_lo[0]), $past(mcr_lo[1])});

    // R10: a masked request stays low
    assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R10: a request implies a pending flag
    assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data[3:0] != 4'd0));
endmodule

bind msr_block msr_block_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .loop_en (loop_en),
    .mcr_lo  (mcr_lo),
    .irq_en  (irq_en),
    .rd_stb  (rd_stb),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/tb_msr_block.sv
// Scoreboard bench: read tasks queue expected bytes; a monitor compares them.
module tb_msr_block;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       loop_en = 1'b0;
    logic [3:0] mcr_lo = 4'd0;
    logic       irq_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    msr_block dut (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
        .dcd_n(dcd_n), .loop_en(loop_en), .mcr_lo(mcr_lo), .irq_en(irq_en),
        .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
    );

    // Monitor: compare each read against the scoreboard
    always @(negedge clk) begin
        #1;
        if (rd_stb) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty: got %02h expected none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s: rd_data got %02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic rd(input logic [7:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        #1;
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq got %0b expected %0b", t, irq, e);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_irq(1'b0, "R1");
        rd(8'h00, "R1");
        // CTS asserts
        @(negedge clk); cts_n = 1'b0; settle();
        rd(8'h11, "R2 R3");
        rd(8'h10, "R5");
        // DSR and DCD assert together
        @(negedge clk); dsr_n = 1'b0; dcd_n = 1'b0; settle();
        rd(8'hBA, "R3");
        rd(8'hB0, "R5");
        // RI leading edge sets no flag, trailing edge does
        @(negedge clk); ri_n = 1'b0; settle();
        rd(8'hF0, "R4 leading");
        @(negedge clk); ri_n = 1'b1; settle();
        rd(8'hB4, "R4 trailing");
        rd(8'hB0, "R5");
        // Interrupt enabled
        irq_en = 1'b1;
        @(negedge clk); cts_n = 1'b1; settle();
        chk_irq(1'b1, "R10 set");
        rd(8'hA1, "R3");
        @(negedge clk); chk_irq(1'b0, "R10 cleared");
        // Interrupt masked
        irq_en = 1'b0;
        @(negedge clk); cts_n = 1'b0; settle();
        chk_irq(1'b0, "R10 masked");
        rd(8'hB1, "R3");
        // Change coincident with read: the flag is kept
        @(negedge clk); dsr_n = 1'b1;
        @(negedge clk);
        rd(8'hB0, "R6 same-cycle");
        rd(8'h92, "R6 kept");
        rd(8'h90, "R5");
        // Enter loopback with all control bits low
        @(negedge clk); mcr_lo = 4'b0000; loop_en = 1'b1; settle();
        rd(8'h09, "R9 enter");
        rd(8'h00, "R7");
        @(negedge clk); mcr_lo = 4'b0010; settle();
        rd(8'h11, "R7 rts");
        @(negedge clk); mcr_lo = 4'b0001; settle();
        rd(8'h23, "R7 dtr");
        @(negedge clk); mcr_lo = 4'b0100; settle();
        rd(8'h42, "R7 out1");
        @(negedge clk); mcr_lo = 4'b1000; settle();
        rd(8'h8C, "R7 out2");
        // Pins are ignored while in loopback
        irq_en = 1'b1;
        @(negedge clk); cts_n = 1'b1; dcd_n = 1'b1; ri_n = 1'b0; settle();
        chk_irq(1'b0, "R8 irq");
        rd(8'h80, "R8");
        // Leave loopback; the pins are idle except RI
        @(negedge clk); ri_n = 1'b1; settle();
        @(negedge clk); loop_en = 1'b0; settle();
        rd(8'h08, "R9 leave");
        rd(8'h00, "R5");
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule